// File: doc/BRIEF.md
# Chip-Select Idle Cycle Inserter

This block sits between an internal bus master and an external memory bus with eight chip-select spaces, numbered 0 to 7. For each access it decides how many idle bus cycles must pass after the previous access before the new one may start. While those idle cycles run, every chip select and both strobes stay negated, so the end of the previous bus cycle is visible on the pins.

Spaces are grouped into four pairs that share one gap-enable bit: space `s` and space `s+4` form pair `s`. Two consecutive accesses that both land in one pair get one idle cycle when that pair's bit is set. A read followed by a write gets a separately programmed turnaround count of 0 to 3 cycles. When both rules apply, the larger of the two counts is used; they are never added.

Requests arrive on a valid/ready stream. The master holds `req_valid` and the payload steady until `req_ready` is seen high at a rising edge. `req_ready` is a function of the request presented: it stays low while the idle cycles that request needs are still running. An accepted request becomes a one-cycle bus access in the cycle right after the accepting edge. A single configuration register is written through `cfg_wr`/`cfg_wdata` and is always visible on `cfg_rdata`.

Top module: `cs_idle_inserter`

## Requirements
- R1: Config bits [3:0] are the pair gap enables. Bit `p` governs spaces `p` and `p+4`, so a space's pair index is its low two bits.
- R2: With pair `p`'s enable at 1, consecutive accesses within pair `p` are separated by exactly one idle cycle. This covers same-space-twice, lower-to-upper and upper-to-lower transitions.
- R3: With pair `p`'s enable at 0, consecutive accesses within pair `p` get no idle cycle from that enable.
- R4: During every idle cycle all of `bus_cs_n` are 1 and both `bus_rd_n` and `bus_wr_n` are 1. At most one chip select is ever low.
- R5: After reset the configuration reads 6'h0F: all four pair enables are 1 and the turnaround count is 0.
- R6: Config bits [5:4] give the read-to-write turnaround count (0 to 3). A write that follows a read waits max(turnaround, pair gap) idle cycles, not their sum.
- R7: Consecutive accesses to different pairs, other than a read followed by a write, are accepted back-to-back with no idle cycle.
- R8: The first request after reset, and any request arriving after enough idle cycles have already passed, is accepted in the cycle it is presented.
- R9: `req_ready` is low while the required idle cycles are pending. An accepted request drives its chip select, its strobe (`bus_rd_n` for `req_write`=0, `bus_wr_n` for 1) and its address for exactly the next cycle.
- R10: A configuration write takes effect for the access decision in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_space | input | 3 | Target chip-select space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data: [5:4] turnaround, [3:0] pair enables |
| cfg_rdata | output | 6 | Current configuration |
| bus_cs_n | output | 8 | Active-low chip selects, one per space |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | 16 | Address of the current bus access |

## Verification
The assertions assume the master obeys the stream rule: once `req_valid` is high it keeps the payload stable until acceptance, and it holds at most one request at a time. The stimulus meets this by driving every request from one task that changes inputs only at falling edges and drops `req_valid` only after the accepting edge. The gap assertion also assumes the configuration does not change while a request is stalled. The bench therefore writes the register only when no request is pending.

// File: rtl/cs_idle_pkg.sv
package cs_idle_pkg;
  localparam int NUM_SPACES = 8;
  localparam int SPACE_W    = $clog2(NUM_SPACES);
  localparam int PAIR_CNT   = NUM_SPACES / 2;
  localparam int PAIR_W     = $clog2(PAIR_CNT);
  localparam int TURN_W     = 2;
  localparam int CFG_W      = PAIR_CNT + TURN_W;

  typedef struct packed {
    logic [TURN_W-1:0]   turn;
    logic [PAIR_CNT-1:0] pair_en;
  } cfg_t;

  function automatic logic [TURN_W-1:0] gap_max(input logic [TURN_W-1:0] a,
                                                input logic [TURN_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cs_idle_cfg.sv
module cs_idle_cfg
  import cs_idle_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = {{TURN_W{1'b0}}, {PAIR_CNT{1'b1}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);
  logic [CFG_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  reg_q <= RESET_VAL;
    else if (wr) reg_q <= wdata;
  end

  assign rdata = reg_q;
  assign cfg   = cfg_t'(reg_q);

  a_r5_reset_value: assert property (@(posedge clk)
    !rst_n |=> (rdata == RESET_VAL));
endmodule

// File: rtl/cs_idle_gap_calc.sv
module cs_idle_gap_calc
  import cs_idle_pkg::*;
(
  input  logic               prev_valid,
  input  logic [SPACE_W-1:0] prev_space,
  input  logic               prev_write,
  input  logic [SPACE_W-1:0] new_space,
  input  logic               new_write,
  input  cfg_t               cfg,
  output logic [TURN_W-1:0]  gap
);
  logic [PAIR_CNT-1:0] pair_hit;
  logic                pair_gap;
  logic [TURN_W-1:0]   turn_gap;

  for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
    assign pair_hit[p] = prev_valid && cfg.pair_en[p] &&
                         (prev_space[PAIR_W-1:0] == PAIR_W'(p)) &&
                         (new_space[PAIR_W-1:0]  == PAIR_W'(p));
  end

  assign pair_gap = |pair_hit;
  assign turn_gap = (prev_valid && !prev_write && new_write) ? cfg.turn : '0;

  always_comb begin
    gap = gap_max(turn_gap, TURN_W'(pair_gap));
  end
endmodule

// File: rtl/cs_idle_seq.sv
module cs_idle_seq
  import cs_idle_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [SPACE_W-1:0]    req_space,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [TURN_W-1:0]     gap,
  output logic                  req_ready,
  output logic                  prev_valid,
  output logic [SPACE_W-1:0]    prev_space,
  output logic                  prev_write,
  output logic [NUM_SPACES-1:0] bus_cs_n,
  output logic                  bus_rd_n,
  output logic                  bus_wr_n,
  output logic [ADDR_W-1:0]     bus_addr
);
  localparam logic [TURN_W-1:0] QMAX = {TURN_W{1'b1}};

  logic [TURN_W-1:0] quiet_q;
  logic              acc;

  assign req_ready = (quiet_q >= gap);
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q    <= QMAX;
      prev_valid <= 1'b0;
      prev_space <= '0;
      prev_write <= 1'b0;
    end else if (acc) begin
      quiet_q    <= '0;
      prev_valid <= 1'b1;
      prev_space <= req_space;
      prev_write <= req_write;
    end else if (quiet_q != QMAX) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_cs_n <= '1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_addr <= '0;
    end else if (acc) begin
      bus_cs_n <= ~(NUM_SPACES'(1) << req_space);
      bus_rd_n <= req_write;
      bus_wr_n <= !req_write;
      bus_addr <= req_addr;
    end else begin
      bus_cs_n <= '1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
    end
  end

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  a_r4_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (&bus_cs_n) |-> (bus_rd_n && bus_wr_n));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(&bus_cs_n) |-> (bus_rd_n != bus_wr_n));
  a_r2_gap_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && gap != '0) |-> (&bus_cs_n));
  a_r9_stall_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (&bus_cs_n));
endmodule

// File: rtl/cs_idle_inserter.sv
module cs_idle_inserter
  import cs_idle_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [SPACE_W-1:0]    req_space,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  cfg_wr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [CFG_W-1:0]      cfg_rdata,
  output logic [NUM_SPACES-1:0] bus_cs_n,
  output logic                  bus_rd_n,
  output logic                  bus_wr_n,
  output logic [ADDR_W-1:0]     bus_addr
);
  cfg_t               cfg;
  logic [TURN_W-1:0]  gap;
  logic               prev_valid;
  logic [SPACE_W-1:0] prev_space;
  logic               prev_write;

  cs_idle_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  cs_idle_gap_calc u_gap (
    .prev_valid (prev_valid),
    .prev_space (prev_space),
    .prev_write (prev_write),
    .new_space  (req_space),
    .new_write  (req_write),
    .cfg        (cfg),
    .gap        (gap)
  );

  cs_idle_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_space  (req_space),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .gap        (gap),
    .req_ready  (req_ready),
    .prev_valid (prev_valid),
    .prev_space (prev_space),
    .prev_write (prev_write),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_addr   (bus_addr)
  );
endmodule

// File: tb/cs_idle_inserter_tb.sv
module cs_idle_inserter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_space = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic [5:0]  cfg_rdata;
  logic [7:0]  bus_cs_n;
  logic        bus_rd_n, bus_wr_n;
  logic [15:0] bus_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_idle_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // caller is just after a falling edge
  task automatic write_cfg(input logic [5:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // present one request, count stall cycles, check the bus access; ends just after a falling edge
  task automatic send(input logic [2:0] s, input logic w, input logic [15:0] a,
                      output int stall);
    req_valid = 1'b1; req_space = s; req_write = w; req_addr = a;
    stall = 0;
    #1;
    while (!req_ready && stall < 8) begin
      @(negedge clk); #1;
      stall++;
      check((&bus_cs_n) && bus_rd_n && bus_wr_n, "R4 idle cycle negated",
            {bus_cs_n, bus_rd_n, bus_wr_n}, 10'h3FF);
    end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(bus_cs_n == ~(8'd1 << s) && bus_rd_n == w && bus_wr_n == !w && bus_addr == a,
          "R9 access on bus", {bus_cs_n, bus_rd_n, bus_wr_n}, {~(8'd1 << s), w, !w});
  endtask

  function automatic int exp_gap(input int sa, input int wa, input int sb, input int wb,
                                 input int en, input int turn);
    int pg, tg;
    pg = ((sa % 4) == (sb % 4) && ((en >> (sa % 4)) & 1)) ? 1 : 0;
    tg = (wa == 0 && wb == 1) ? turn : 0;
    return (pg > tg) ? pg : tg;
  endfunction

  initial begin
    int st;
    int en_pat[3] = '{4'hF, 4'h0, 4'h5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(cfg_rdata == 6'h0F, "R5 reset config", cfg_rdata, 6'h0F);
    check(bus_cs_n == 8'hFF && bus_rd_n && bus_wr_n, "R4 reset bus idle", bus_cs_n, 8'hFF);
    check(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
    send(3'd6, 1'b0, 16'h1234, st);
    check(st == 0, "R8 first access immediate", st, 0);

    // R10: config write applies to the very next decision
    idle_cycles(4);
    write_cfg(6'h30);
    check(cfg_rdata == 6'h30, "R10 readback", cfg_rdata, 6'h30);
    send(3'd1, 1'b0, 16'h0011, st);
    send(3'd2, 1'b1, 16'h0022, st);
    check(st == 3, "R10 R6 turnaround 3 applied", st, 3);

    // R8: a request arriving after enough idle passes straight through
    send(3'd2, 1'b0, 16'h0033, st);
    idle_cycles(3);
    send(3'd2, 1'b1, 16'h0044, st);
    check(st == 0, "R8 idle already elapsed", st, 0);

    // sweep: enable patterns x turnaround x all space pairs x rd/wr combos
    foreach (en_pat[e]) begin
      for (int t = 0; t < 4; t++) begin
        idle_cycles(4);
        write_cfg(6'((t << 4) | en_pat[e]));
        for (int sa = 0; sa < 8; sa++) begin
          for (int sb = 0; sb < 8; sb++) begin
            for (int rw = 0; rw < 4; rw++) begin
              int wa, wb, eg;
              wa = rw & 1; wb = (rw >> 1) & 1;
              eg = exp_gap(sa, wa, sb, wb, en_pat[e], t);
              idle_cycles(4);
              send(3'(sa), 1'(wa), 16'(sa * 256 + rw), st);
              check(st == 0, "R8 first after idle", st, 0);
              send(3'(sb), 1'(wb), 16'(sb * 16 + t), st);
              if ((sa % 4) == (sb % 4) && !(wa == 0 && wb == 1))
                check(st == eg, ((en_pat[e] >> (sa % 4)) & 1) ? "R2 pair gap" : "R3 pair gap off",
                      st, eg);
              else if ((sa % 4) != (sb % 4) && !(wa == 0 && wb == 1))
                check(st == eg, "R7 no gap across pairs", st, eg);
              else
                check(st == eg, "R6 max of turnaround and pair gap (R1 mapping)", st, eg);
            end
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule